// File: doc/BRIEF.md
# Receive Byte Queue with Status Word and Delayed Interrupt

This block sits between a serial receiver and a host processor. Each time the receiver finishes a character, it offers one byte with a one-cycle strobe. The block holds up to sixteen bytes in arrival order. The host drains them through a read port that returns one 16-bit word per read. The low byte of the word is the oldest stored byte and the high byte is a status field. The host pops by asserting a read request for one cycle. The word it sees in that cycle describes the queue before the pop takes effect. When the status says no data is present, the host throws the data byte away. So the host can keep reading until the present flag drops.

The main concern is a receiver byte and a host pop landing on the same clock edge. In that case the incoming byte is always kept and the order is preserved, whatever the fill level. This includes an empty queue, a queue with one byte and a full queue. A host interrupt is held off for a programmable number of character times after the queue stops being empty, so that several bytes collect before the host is notified. It drops as soon as the queue is empty again.

Top module: `rx_byte_queue`

## Requirements
- R1: The read word carries the oldest byte in bits [7:0]. Bit 8 is data-present (queue not empty), bit 9 is full (sixteen bytes held), bit 10 is the sticky overflow flag, and bits [15:11] read as zero. The word shows the state before any pop in the same cycle.
- R2: Bytes come out in the order they were accepted, and up to DEPTH (16) bytes are held at once.
- R3: A read request while the queue is empty returns data-present 0 and changes nothing else. A byte pushed later is the next byte returned.
- R4: A push and a read request on the same edge while the queue is empty store the pushed byte, so the queue then holds exactly that byte.
- R5: A push and a read request on the same edge while the queue is partly filled remove the oldest byte, append the new one, and leave the fill level unchanged.
- R6: A push and a read request on the same edge while the queue is full keep the pushed byte and do not set the overflow flag.
- R7: A push into a full queue with no read request in that cycle discards the byte and sets the overflow flag. The flag stays set until the edge of the next read request and is visible in the word returned by that read.
- R8: The interrupt output rises exactly DELAY edges after the edge that made the queue non-empty, and stays high while the queue is non-empty.
- R9: The interrupt is low whenever the queue is empty, and the delay count starts again from zero each time the queue empties.
- R10: DELAY equals (CLK_HZ / BAUD) × CHAR_BITS × DELAY_CHARS, with default values of 90 MHz, 38400 baud, 10 bits per character and 4 characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | One-cycle strobe from the receiver, a byte is complete |
| pushByte | input | 8 | Received byte |
| popReq | input | 1 | Host read request; pops the oldest byte at the edge |
| readWord | output | 16 | Status byte in [15:8], oldest data byte in [7:0] |
| irq | output | 1 | Delayed data-waiting interrupt to the host |

## Verification
Directed sequences place a simultaneous push and pop at fill levels zero, one and sixteen. These are the only levels where a flawed pointer or count update would lose, duplicate or reorder a byte. Filling past capacity with and without a concurrent read separates a true drop-with-overflow from a legal replace. An idle stretch after the first byte pins the interrupt edge to the exact cycle. Phases of random traffic, with push-heavy, pop-heavy and balanced mixes, drive the queue through every level, including repeated empty-then-refill runs that show whether the interrupt delay restarts.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes from control to datapath, already qualified against occupancy
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } rxq_strobe_t;

  // Status bit offsets inside the upper byte of the read word
  localparam int STAT_PRESENT = 0;
  localparam int STAT_FULL    = 1;
  localparam int STAT_OVF     = 2;
  localparam int STAT_USED    = 3;

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxq_strobe_t       strobe,
  input  logic [DATA_W-1:0] pushByte,
  output logic [DATA_W-1:0] headByte
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= nextIdx(wrPtr);
      if (strobe.rdEn) rdPtr <= nextIdx(rdPtr);
    end
  end

  assign headByte = store[rdPtr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DELAY_CYC = 93720
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           pushValid,
  input  logic                           popReq,
  output rxq_strobe_t                    strobe,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           ovfFlag,
  output logic                           irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TMR_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(DEPTH);
  localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(DELAY_CYC);

  logic             isEmpty, isFull, doPop, doPush;
  logic [TMR_W-1:0] timer;

  assign isEmpty = (level == '0);
  assign isFull  = (level == FULL_LVL);

  // A pop of an empty queue is a no-op; a push into a full queue is
  // accepted only when the same edge frees a slot.
  assign doPop  = popReq && !isEmpty;
  assign doPush = pushValid && (!isFull || doPop);

  assign strobe.wrEn = doPush;
  assign strobe.rdEn = doPop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else begin
      unique case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (pushValid && !doPush) begin
      ovfFlag <= 1'b1;
    end else if (popReq) begin
      ovfFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || isEmpty) begin
      timer <= '0;
    end else if (timer != TMR_LIMIT) begin
      timer <= timer + 1'b1;
    end
  end

  assign irq = (timer == TMR_LIMIT) && !isEmpty;

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 8,
  parameter int CLK_HZ      = 90_000_000,
  parameter int BAUD        = 38_400,
  parameter int CHAR_BITS   = 10,
  parameter int DELAY_CHARS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [DATA_W-1:0]   pushByte,
  input  logic                popReq,
  output logic [2*DATA_W-1:0] readWord,
  output logic                irq
);

  localparam int DELAY_CYC = (CLK_HZ / BAUD) * CHAR_BITS * DELAY_CHARS;
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  rxq_strobe_t       strobe;
  logic [CNT_W-1:0]  level;
  logic              ovfFlag;
  logic [DATA_W-1:0] headByte;
  logic [DATA_W-1:0] statByte;

  rxq_ctrl #(.DEPTH(DEPTH), .DELAY_CYC(DELAY_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .strobe(strobe), .level(level), .ovfFlag(ovfFlag), .irq(irq)
  );

  rxq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushByte(pushByte),
    .headByte(headByte)
  );

  always_comb begin
    statByte               = '0;
    statByte[STAT_PRESENT] = (level != '0);
    statByte[STAT_FULL]    = (level == FULL_LVL);
    statByte[STAT_OVF]     = ovfFlag;
  end

  assign readWord = {statByte, headByte};

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int WORD_W = 16,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              popReq,
  input logic [WORD_W-1:0] readWord,
  input logic              irq,
  input logic [CNT_W-1:0]  level
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam int OVF_POS = WORD_W / 2 + 2;

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0 && popReq && !pushValid) |=> (level == '0));

  assert_push_pop_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0 && popReq && pushValid) |=> (level == CNT_W'(1)));

  assert_push_pop_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (level != '0 && popReq && pushValid) |=> $stable(level));

  assert_full_replace_R6: assert property (@(posedge clk) disable iff (!rstN)
    (level == FULL_LVL && popReq && pushValid) |=> !readWord[OVF_POS]);

  assert_overflow_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (level == FULL_LVL && pushValid && !popReq) |=> readWord[OVF_POS]);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && level > CNT_W'(1)) |=> irq);

  assert_irq_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !irq);

endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH), .WORD_W(2*DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
  .readWord(readWord), .irq(irq), .level(level)
);

// File: tb/rx_byte_queue_tb_top.sv
`timescale 1ns/1ps
module rx_byte_queue_tb_top;

  localparam int DEPTH       = 16;
  localparam int CLK_HZ      = 1_000_000;
  localparam int BAUD        = 100_000;
  localparam int CHAR_BITS   = 10;
  localparam int DELAY_CHARS = 4;
  // R10: delay derived from the requirement formula
  localparam int LIMIT = (CLK_HZ / BAUD) * CHAR_BITS * DELAY_CHARS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [7:0]  pushByte = '0;
  logic        popReq = 1'b0;
  logic [15:0] readWord;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  logic [7:0] modelQ[$];
  bit         modelOvf = 1'b0;
  int         modelTimer = 0;

  always #10 clk = ~clk;

  rx_byte_queue #(
    .DEPTH(DEPTH), .DATA_W(8), .CLK_HZ(CLK_HZ), .BAUD(BAUD),
    .CHAR_BITS(CHAR_BITS), .DELAY_CHARS(DELAY_CHARS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushByte(pushByte),
    .popReq(popReq), .readWord(readWord), .irq(irq)
  );

  function automatic logic [7:0] expStatus();
    logic [7:0] s;
    s = '0;
    s[0] = (modelQ.size() != 0);
    s[1] = (modelQ.size() == DEPTH);
    s[2] = modelOvf;
    return s;
  endfunction

  function automatic bit expIrq();
    return (modelTimer == LIMIT) && (modelQ.size() != 0);
  endfunction

  task automatic checkOutputs(input string tag);
    logic [7:0] es;
    es = expStatus();
    testsRun++;
    if (readWord[15:8] !== es) begin
      testsFailed++;
      $display("FAIL %s status actual=%h expected=%h", tag, readWord[15:8], es);
    end
    if (modelQ.size() != 0) begin
      testsRun++;
      if (readWord[7:0] !== modelQ[0]) begin
        testsFailed++;
        $display("FAIL %s data actual=%h expected=%h", tag, readWord[7:0], modelQ[0]);
      end
    end
    testsRun++;
    if (irq !== expIrq()) begin
      testsFailed++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, expIrq());
    end
  endtask

  task automatic modelEdge(input bit push, input logic [7:0] b, input bit pop);
    bit dp, dw;
    dp = pop && (modelQ.size() != 0);
    dw = push && ((modelQ.size() < DEPTH) || dp);
    if (modelQ.size() == 0) modelTimer = 0;
    else if (modelTimer < LIMIT) modelTimer++;
    if (dp) void'(modelQ.pop_front());
    if (dw) modelQ.push_back(b);
    if (push && !dw) modelOvf = 1'b1;
    else if (pop) modelOvf = 1'b0;
  endtask

  task automatic step(input bit push, input logic [7:0] b, input bit pop, input string tag);
    @(negedge clk);
    pushValid = push;
    pushByte  = b;
    popReq    = pop;
    #1;
    checkOutputs(tag);
    @(posedge clk);
    modelEdge(push, b, pop);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // Reset state: empty, no flags, no interrupt (R1 R9)
    step(0, 8'h00, 0, "R1 reset");

    // R3: reads of an empty queue change nothing
    step(0, 8'h00, 1, "R3");
    step(0, 8'h00, 1, "R3");
    step(1, 8'h3C, 0, "R3");
    step(0, 8'h00, 1, "R3 first byte after empty reads");
    step(0, 8'h00, 0, "R3 empty again");

    // R4: simultaneous push and read on an empty queue
    step(1, 8'hA5, 1, "R4");
    step(0, 8'h00, 0, "R4 byte kept");
    // R5: simultaneous at level 1, then at level 3
    step(1, 8'h5A, 1, "R5 level1");
    step(1, 8'h11, 0, "R5");
    step(1, 8'h22, 0, "R5");
    step(1, 8'h33, 1, "R5 level3");
    for (int k = 0; k < 3; k++) step(0, 8'h00, 1, "R5 drain");
    step(0, 8'h00, 0, "R5 empty");

    // R2: fill to capacity, full flag set (R1 layout)
    for (int k = 0; k < DEPTH; k++) step(1, 8'(8'h40 + k), 0, "R2 fill");
    step(0, 8'h00, 0, "R2 full");
    // R6: replace while full, no overflow
    step(1, 8'hE6, 1, "R6");
    step(0, 8'h00, 0, "R6 after");
    // R7: push into full without read drops, flag sticky
    step(1, 8'hEE, 0, "R7");
    step(1, 8'hEF, 0, "R7");
    step(0, 8'h00, 0, "R7 sticky");
    step(0, 8'h00, 1, "R7 read shows flag");
    step(0, 8'h00, 0, "R7 cleared");
    for (int k = 0; k < DEPTH; k++) step(0, 8'h00, 1, "R2 drain order");
    step(0, 8'h00, 0, "R9 empty");

    // R8 R10: interrupt rises exactly LIMIT edges after the first byte
    step(1, 8'h77, 0, "R8");
    for (int k = 0; k < LIMIT + 5; k++) step(0, 8'h00, 0, "R8 R10 delay");
    step(1, 8'h78, 1, "R8 hold");
    step(0, 8'h00, 1, "R9 drop");
    // R9: restart of the delay after emptying
    step(1, 8'h79, 0, "R9 restart");
    for (int k = 0; k < LIMIT + 2; k++) step(0, 8'h00, 0, "R9 R10 restart delay");
    step(0, 8'h00, 1, "R9");

    // Random traffic in biased phases
    for (int ph = 0; ph < 8; ph++) begin
      int pPush, pPop;
      case (ph % 4)
        0: begin pPush = 70; pPop = 20; end
        1: begin pPush = 20; pPop = 70; end
        2: begin pPush = 50; pPop = 50; end
        default: begin pPush = 90; pPop = 85; end
      endcase
      for (int k = 0; k < 500; k++) begin
        bit pu, po;
        pu = ($urandom_range(99) < pPush);
        po = ($urandom_range(99) < pPop);
        step(pu, 8'($urandom), po, "R5 random");
      end
      for (int k = 0; k < 20; k++) step(0, 8'h00, 1, "R2 random drain");
    end

    step(0, 8'h00, 0, "R1 final");
    finishRun();
  end

endmodule